// File: doc/BRIEF.md
# Mixed-Width Register Access Splitter

This block sits between a big-endian processor-side bus and a 512-byte peripheral register window. The registers in the window are one, two or four bytes wide. A width map, fixed at build time, gives one two-bit code for each 4-byte group of the window. The block looks up the register width for every incoming byte, halfword or word request. It then turns the request into the native-width accesses that the register file behind it accepts.

When a request is wider than the register, it is broken into consecutive native accesses at rising addresses. The read data from those accesses is packed back into one big-endian result. When a request is narrower than the register, a read returns the addressed byte lane of a single native read. A narrower write becomes a read, a merge and a write-back of the whole register. A request that falls outside the window, is misaligned, or lands on an unpopulated group ends with an error response and does not reach the register file. The register file is reached through a simple target port. That port returns read data combinationally and takes one access per cycle.

Top module: `mixw_access_splitter`

## Requirements
- R1: A request whose offset is 512 or more (any `req_addr` bit above bit 8 set) returns `rsp_err` = 1 and issues no target access.
- R2: A request with size code 3, a halfword (code 1) at an odd offset, or a word (code 2) at an offset that is not a multiple of 4 returns an error and issues no target access. Size code 0 is a byte.
- R3: The width map holds two bits per 4-byte group, with group g at map bits 2g+1:2g. The group is `req_addr[8:2]`. Code 0 is a hole, 1 a byte register, 2 a halfword register and 3 a word register. A request on a hole returns an error with no target access. By default, groups 0-15 are byte, 16-31 halfword, 32-47 word and 48-63 holes. Every group g from 64 up takes code g mod 4.
- R4: When the request size equals the native width, exactly one target access is made, with the same offset, size, direction and data. The response follows in the next cycle.
- R5: A read wider than the register issues (request bytes / native bytes) native reads, one per cycle, at offset + i × native bytes. The data is assembled big-endian, with the first access in the most significant position.
- R6: A write wider than the register is split in the same way. The most significant native slice of the write data goes to the lowest offset.
- R7: A read narrower than the register issues one native read at the aligned register offset. It returns the addressed lane, where byte offset 0 inside the register is the most significant byte.
- R8: A write narrower than the register issues a native read and then a native write to the same aligned offset in consecutive cycles. Only the addressed lane changes.
- R9: A request is taken only when `busy` is low. `busy` rises after acceptance and stays high through the response cycle. A request held while `busy` is high has no effect.
- R10: `rsp_valid` is a one-cycle pulse. `rsp_rdata` is right-justified and zero-extended, and it is zero for writes and errors.
- R11: During reset and on leaving it, `busy`, `rsp_valid`, `rsp_err` and `tgt_valid` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 illegal |
| req_addr | input | 12 | Byte offset into the window |
| req_wdata | input | 32 | Write data, right-justified |
| busy | output | 1 | A request is in progress; new requests are not taken |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Read result, right-justified |
| rsp_err | output | 1 | Request was rejected |
| tgt_valid | output | 1 | Target access this cycle |
| tgt_write | output | 1 | Target access is a write |
| tgt_size | output | 2 | Native size code of the target access |
| tgt_addr | output | 9 | Byte offset of the target access |
| tgt_wdata | output | 32 | Target write data, right-justified |
| tgt_rdata | input | 32 | Target read data, right-justified, same cycle |

## Verification
The assertions assume a target that answers reads in the same cycle. They also assume that the request fields matter only in the cycle they are taken. Neither property is checked inside the block, so the bench models the register file as a zero-latency byte array and changes request fields only on falling edges. The native-size assertion also assumes that the width map never assigns a wide register to a group whose accesses could be misaligned. The default map and every map in the bench satisfy this, because every group is a full 4-byte group. The bench holds `req_valid` high with conflicting write data during a long split. This checks that the lack of acceptance while busy is visible at the ports.

// File: rtl/mixw_pkg.sv
package mixw_pkg;

   localparam int MAP_GROUPS = 128;

   localparam logic [1:0] NAT_HOLE = 2'd0;
   localparam logic [1:0] NAT_BYTE = 2'd1;
   localparam logic [1:0] NAT_HALF = 2'd2;
   localparam logic [1:0] NAT_WORD = 2'd3;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_HALF = 2'd1;
   localparam logic [1:0] SZ_WORD = 2'd2;
   localparam logic [1:0] SZ_NONE = 2'd3;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_BEAT  = 2'd1,
      ST_WBACK = 2'd2,
      ST_DONE  = 2'd3
   } split_state_e;

   // Default layout: byte block, halfword block, word block, hole block,
   // then a repeating mixture in the upper half of the window.
   function automatic logic [2*MAP_GROUPS-1:0] default_map();
      logic [2*MAP_GROUPS-1:0] m;
      m = '0;
      for (int g = 0; g < MAP_GROUPS; g++) begin
         logic [1:0] c;
         if (g < 16)      c = NAT_BYTE;
         else if (g < 32) c = NAT_HALF;
         else if (g < 48) c = NAT_WORD;
         else if (g < 64) c = NAT_HOLE;
         else             c = 2'(g % 4);
         m[2*g +: 2] = c;
      end
      return m;
   endfunction

   function automatic logic [31:0] size_mask(logic [1:0] s);
      case (s)
         SZ_BYTE: return 32'h0000_00FF;
         SZ_HALF: return 32'h0000_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   function automatic logic [5:0] size_bits(logic [1:0] s);
      return 6'd8 << s;
   endfunction

endpackage

// File: rtl/mixw_width_lookup.sv
module mixw_width_lookup
   import mixw_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int WIN_BYTES = 512,
   parameter logic [2*MAP_GROUPS-1:0] MAP = default_map()
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   output logic              reject,
   output logic [1:0]        native
);
   localparam int NGRP  = WIN_BYTES / 4;
   localparam int GRP_W = $clog2(NGRP);
   localparam int WB_W  = $clog2(WIN_BYTES);

   if (WIN_BYTES > 4*MAP_GROUPS || WIN_BYTES < 8 || (WIN_BYTES & (WIN_BYTES-1)) != 0)
      $error("mixw_width_lookup: WIN_BYTES must be a power of two within the map");
   if (ADDR_W < WB_W)
      $error("mixw_width_lookup: ADDR_W cannot cover the window");

   logic [GRP_W-1:0] grp;
   logic [1:0]       code;
   logic             outside;
   logic             misalign;

   assign grp  = addr[GRP_W+1:2];
   assign code = MAP[{grp, 1'b0} +: 2];

   // Variant: address wider than the window needs an out-of-range check.
   if (ADDR_W > WB_W) begin : g_range
      assign outside = |addr[ADDR_W-1:WB_W];
   end else begin : g_norange
      assign outside = 1'b0;
   end

   always_comb begin
      case (size)
         SZ_BYTE: misalign = 1'b0;
         SZ_HALF: misalign = addr[0];
         SZ_WORD: misalign = |addr[1:0];
         default: misalign = 1'b1;
      endcase
   end

   assign native = code - 2'd1;
   assign reject = outside | misalign | (code == NAT_HOLE);

endmodule

// File: rtl/mixw_beat_plan.sv
module mixw_beat_plan
   import mixw_pkg::*;
#(
   parameter int WA = 9
) (
   input  logic [1:0]    req_size,
   input  logic [1:0]    nat_size,
   input  logic [WA-1:0] base,
   input  logic [1:0]    idx,
   output logic          over,
   output logic          under,
   output logic [1:0]    last_idx,
   output logic [WA-1:0] beat_addr,
   output logic [4:0]    lane_sh,
   output logic [4:0]    slice_sh
);
   if (WA < 3) $error("mixw_beat_plan: WA too small");

   logic [WA-1:0] nmask;
   logic [2:0]    nb, sb, off3, diff;
   logic [1:0]    rem;

   always_comb begin
      case (nat_size)
         SZ_BYTE: nmask = '0;
         SZ_HALF: nmask = WA'(1);
         default: nmask = WA'(3);
      endcase
   end

   assign over  = req_size > nat_size;
   assign under = req_size < nat_size;

   assign last_idx = !over ? 2'd0 :
                     ((req_size - nat_size) == 2'd1) ? 2'd1 : 2'd3;

   assign beat_addr = over ? base + (WA'(idx) << nat_size) : (base & ~nmask);

   // Big-endian lane position of a narrow request inside the native register.
   assign nb   = 3'd1 << nat_size;
   assign sb   = 3'd1 << req_size;
   assign off3 = {1'b0, base[1:0] & nmask[1:0]};
   assign diff = nb - sb - off3;
   assign lane_sh = under ? {diff[1:0], 3'b000} : 5'd0;

   // Slice of wide write data carried by beat idx: earliest beat = top slice.
   assign rem      = last_idx - idx;
   assign slice_sh = over ? ({3'b000, rem} << ({1'b0, nat_size} + 3'd3)) : 5'd0;

endmodule

// File: rtl/mixw_lane_merge.sv
module mixw_lane_merge
   import mixw_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic [1:0]        req_size,
   input  logic [1:0]        nat_size,
   input  logic [4:0]        lane_sh,
   input  logic [4:0]        slice_sh,
   input  logic [DATA_W-1:0] nat_rd,
   input  logic [DATA_W-1:0] req_wd,
   input  logic [DATA_W-1:0] acc,
   output logic [DATA_W-1:0] ext_rd,
   output logic [DATA_W-1:0] merged_wd,
   output logic [DATA_W-1:0] slice_wd,
   output logic [DATA_W-1:0] pass_wd,
   output logic [DATA_W-1:0] acc_next
);
   if (DATA_W != 32) $error("mixw_lane_merge: only a 32-bit data path is supported");

   logic [DATA_W-1:0] rmask, nmask, rd_n;

   assign rmask = size_mask(req_size);
   assign nmask = size_mask(nat_size);
   assign rd_n  = nat_rd & nmask;

   assign ext_rd    = (rd_n >> lane_sh) & rmask;
   assign merged_wd = (rd_n & ~(rmask << lane_sh)) | ((req_wd & rmask) << lane_sh);
   assign slice_wd  = (req_wd >> slice_sh) & nmask;
   assign pass_wd   = req_wd & rmask;
   assign acc_next  = (nat_size == SZ_WORD) ? rd_n : ((acc << size_bits(nat_size)) | rd_n);

endmodule

// File: rtl/mixw_access_splitter.sv
module mixw_access_splitter
   import mixw_pkg::*;
#(
   parameter int ADDR_W    = 12,
   parameter int WIN_BYTES = 512,
   parameter int DATA_W    = 32,
   parameter logic [2*MAP_GROUPS-1:0] WIDTH_MAP = default_map(),
   localparam int WA = $clog2(WIN_BYTES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [1:0]        req_size,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              busy,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              rsp_err,
   output logic              tgt_valid,
   output logic              tgt_write,
   output logic [1:0]        tgt_size,
   output logic [WA-1:0]     tgt_addr,
   output logic [DATA_W-1:0] tgt_wdata,
   input  logic [DATA_W-1:0] tgt_rdata
);
   if (DATA_W != 32) $error("mixw_access_splitter: DATA_W must be 32");

   split_state_e      state;
   logic              q_write, q_err;
   logic [1:0]        q_size, q_nat, idx;
   logic [WA-1:0]     q_addr;
   logic [DATA_W-1:0] q_wdata, q_rdata, acc, hold;

   logic              lk_reject;
   logic [1:0]        lk_native;
   logic              over, under;
   logic [1:0]        last_idx;
   logic [WA-1:0]     beat_addr;
   logic [4:0]        lane_sh, slice_sh;
   logic [DATA_W-1:0] nat_rd, ext_rd, merged_wd, slice_wd, pass_wd, acc_next;

   mixw_width_lookup #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .MAP(WIDTH_MAP)) u_lookup (
      .addr(req_addr), .size(req_size), .reject(lk_reject), .native(lk_native)
   );

   mixw_beat_plan #(.WA(WA)) u_plan (
      .req_size(q_size), .nat_size(q_nat), .base(q_addr), .idx(idx),
      .over(over), .under(under), .last_idx(last_idx), .beat_addr(beat_addr),
      .lane_sh(lane_sh), .slice_sh(slice_sh)
   );

   assign nat_rd = (state == ST_WBACK) ? hold : tgt_rdata;

   mixw_lane_merge #(.DATA_W(DATA_W)) u_lanes (
      .req_size(q_size), .nat_size(q_nat), .lane_sh(lane_sh), .slice_sh(slice_sh),
      .nat_rd(nat_rd), .req_wd(q_wdata), .acc(acc),
      .ext_rd(ext_rd), .merged_wd(merged_wd), .slice_wd(slice_wd),
      .pass_wd(pass_wd), .acc_next(acc_next)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         q_write <= 1'b0;
         q_err   <= 1'b0;
         q_size  <= SZ_BYTE;
         q_nat   <= SZ_BYTE;
         q_addr  <= '0;
         q_wdata <= '0;
         q_rdata <= '0;
         acc     <= '0;
         hold    <= '0;
         idx     <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  q_write <= req_write;
                  q_size  <= req_size;
                  q_nat   <= lk_native;
                  q_addr  <= req_addr[WA-1:0];
                  q_wdata <= req_wdata;
                  q_err   <= lk_reject;
                  q_rdata <= '0;
                  acc     <= '0;
                  idx     <= '0;
                  state   <= lk_reject ? ST_DONE : ST_BEAT;
               end
            end
            ST_BEAT: begin
               if (under) begin
                  if (q_write) begin
                     hold  <= tgt_rdata;
                     state <= ST_WBACK;
                  end else begin
                     q_rdata <= ext_rd;
                     state   <= ST_DONE;
                  end
               end else begin
                  acc <= acc_next;
                  if (idx == last_idx) begin
                     if (!q_write) q_rdata <= acc_next;
                     state <= ST_DONE;
                  end else begin
                     idx <= idx + 2'd1;
                  end
               end
            end
            ST_WBACK: state <= ST_DONE;
            default:  state <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      tgt_valid = (state == ST_BEAT) || (state == ST_WBACK);
      tgt_write = (state == ST_WBACK) || (state == ST_BEAT && q_write && !under);
      tgt_addr  = beat_addr;
      tgt_size  = q_nat;
      if (state == ST_WBACK)  tgt_wdata = merged_wd;
      else if (!tgt_write)    tgt_wdata = '0;
      else if (over)          tgt_wdata = slice_wd;
      else                    tgt_wdata = pass_wd;
   end

   assign busy      = (state != ST_IDLE);
   assign rsp_valid = (state == ST_DONE);
   assign rsp_err   = (state == ST_DONE) && q_err;
   assign rsp_rdata = (state == ST_DONE) ? q_rdata : '0;

   // Independent lookup of each issued target access against the width map.
   logic       chk_reject;
   logic [1:0] chk_native;

   mixw_width_lookup #(.ADDR_W(WA), .WIN_BYTES(WIN_BYTES), .MAP(WIDTH_MAP)) u_chk_lookup (
      .addr(tgt_addr), .size(tgt_size), .reject(chk_reject), .native(chk_native)
   );

   AST_TGT_NATIVE_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_valid |-> (!chk_reject && tgt_size == chk_native)); // R4

   AST_ERR_SKIPS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> $past(!tgt_valid)); // R1

   AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R10

   AST_TGT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      tgt_valid |-> busy); // R9

   AST_ACCEPT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_valid)); // R9

   AST_RMW_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
      (tgt_valid && tgt_write && under) |->
         ($past(tgt_valid && !tgt_write) && tgt_addr == $past(tgt_addr))); // R8

endmodule

// File: tb/mixw_access_splitter_test.sv
`timescale 1ns/1ps
module mixw_access_splitter_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0;
   logic [1:0]  req_size = 2'd0;
   logic [11:0] req_addr = '0;
   logic [31:0] req_wdata = '0;
   logic        busy, rsp_valid, rsp_err, tgt_valid, tgt_write;
   logic [31:0] rsp_rdata, tgt_wdata, tgt_rdata;
   logic [1:0]  tgt_size;
   logic [8:0]  tgt_addr;

   always #2 clk = ~clk;

   mixw_access_splitter uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_size(req_size), .req_addr(req_addr), .req_wdata(req_wdata),
      .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
      .tgt_valid(tgt_valid), .tgt_write(tgt_write), .tgt_size(tgt_size),
      .tgt_addr(tgt_addr), .tgt_wdata(tgt_wdata), .tgt_rdata(tgt_rdata)
   );

   logic [7:0] tmem [512];
   logic [7:0] rmem [512];
   int n_tests = 0;
   int n_fail  = 0;

   always_comb begin
      case (tgt_size)
         2'd0:    tgt_rdata = {24'h0, tmem[tgt_addr]};
         2'd1:    tgt_rdata = {16'h0, tmem[tgt_addr], tmem[tgt_addr + 9'd1]};
         default: tgt_rdata = {tmem[tgt_addr], tmem[tgt_addr + 9'd1],
                               tmem[tgt_addr + 9'd2], tmem[tgt_addr + 9'd3]};
      endcase
   end

   always @(posedge clk) begin
      if (tgt_valid && tgt_write) begin
         case (tgt_size)
            2'd0: tmem[tgt_addr] <= tgt_wdata[7:0];
            2'd1: begin
               tmem[tgt_addr]        <= tgt_wdata[15:8];
               tmem[tgt_addr + 9'd1] <= tgt_wdata[7:0];
            end
            default: begin
               tmem[tgt_addr]        <= tgt_wdata[31:24];
               tmem[tgt_addr + 9'd1] <= tgt_wdata[23:16];
               tmem[tgt_addr + 9'd2] <= tgt_wdata[15:8];
               tmem[tgt_addr + 9'd3] <= tgt_wdata[7:0];
            end
         endcase
      end
   end

   function automatic logic [1:0] exp_code(logic [11:0] a);
      int g;
      g = int'(a) / 4;
      if (g < 16) return 2'd1;
      if (g < 32) return 2'd2;
      if (g < 48) return 2'd3;
      if (g < 64) return 2'd0;
      return 2'(g % 4);
   endfunction

   function automatic logic [31:0] ref_read(logic [11:0] a, int nbytes);
      logic [31:0] v;
      v = '0;
      for (int k = 0; k < nbytes; k++) v = (v << 8) | {24'h0, rmem[9'(a) + 9'(k)]};
      return v;
   endfunction

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Issues one request, observes the target port, checks every result.
   task automatic run(input bit wr, input logic [1:0] sz, input logic [11:0] a,
                      input logic [31:0] wd, input bit poke, input string tag);
      logic [8:0]  lg_addr [8];
      bit          lg_wr   [8];
      logic [1:0]  lg_sz   [8];
      logic [31:0] rd;
      logic        er;
      int          cyc, nacc, nb, sbytes, exp_n;
      bit          exp_err;

      exp_err = (a >= 12'd512) || (sz == 2'd3) || (sz == 2'd1 && a[0]) ||
                (sz == 2'd2 && a[1:0] != 2'd0) || (a < 12'd512 && exp_code(a) == 2'd0);

      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_size = sz; req_addr = a; req_wdata = wd;
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      cyc = 1; nacc = 0;
      while (!rsp_valid && cyc < 50) begin
         if (poke) begin
            req_valid = 1'b1; req_write = 1'b1; req_size = 2'd0;
            req_addr = 12'h010; req_wdata = 32'h0000_00A5;
         end
         if (tgt_valid && nacc < 8) begin
            lg_addr[nacc] = tgt_addr; lg_wr[nacc] = tgt_write; lg_sz[nacc] = tgt_size;
            nacc++;
         end
         @(negedge clk);
         cyc++;
      end
      req_valid = 1'b0;
      rd = rsp_rdata; er = rsp_err;
      @(negedge clk);
      chk(!rsp_valid, {tag, " R10 pulse"}, {31'h0, rsp_valid}, 32'h0);

      chk(er == exp_err, {tag, " error flag"}, {31'h0, er}, {31'h0, exp_err});
      if (exp_err) begin
         chk(nacc == 0 && cyc == 1, {tag, " no target access"}, 32'(nacc), 32'h0);
         chk(rd == 32'h0, {tag, " R10 zero data"}, rd, 32'h0);
      end else begin
         nb     = 1 << (int'(exp_code(a)) - 1);
         sbytes = 1 << int'(sz);
         exp_n  = (sbytes > nb) ? sbytes / nb : ((sbytes < nb && wr) ? 2 : 1);
         chk(nacc == exp_n, {tag, " access count"}, 32'(nacc), 32'(exp_n));
         chk(cyc == exp_n + 1, {tag, " latency"}, 32'(cyc), 32'(exp_n + 1));
         for (int i = 0; i < nacc && i < exp_n; i++) begin
            logic [8:0] ea;
            bit         ew;
            ea = (sbytes > nb) ? 9'(a) + 9'(i * nb) : (9'(a) & ~9'(nb - 1));
            ew = (sbytes >= nb) ? wr : (wr && i == 1);
            chk(lg_addr[i] == ea, {tag, " access offset"}, 32'(lg_addr[i]), 32'(ea));
            chk(lg_wr[i] == ew, {tag, " access direction"}, 32'(lg_wr[i]), 32'(ew));
            chk(lg_sz[i] == exp_code(a) - 2'd1, {tag, " access size"}, 32'(lg_sz[i]),
                32'(exp_code(a) - 2'd1));
         end
         if (wr) begin
            chk(rd == 32'h0, {tag, " R10 write data zero"}, rd, 32'h0);
            for (int k = 0; k < sbytes; k++)
               rmem[9'(a) + 9'(k)] = 8'(wd >> (8 * (sbytes - 1 - k)));
         end else begin
            chk(rd == ref_read(a, sbytes), {tag, " read data"}, rd, ref_read(a, sbytes));
         end
      end
   endtask

   task automatic t_reset();
      chk(!busy && !rsp_valid && !rsp_err && !tgt_valid, "R11 in reset",
          {28'h0, busy, rsp_valid, rsp_err, tgt_valid}, 32'h0);
      @(negedge clk); rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !rsp_valid && !rsp_err && !tgt_valid, "R11 after reset",
          {28'h0, busy, rsp_valid, rsp_err, tgt_valid}, 32'h0);
   endtask

   task automatic t_matched();
      run(1'b0, 2'd0, 12'h005, 32'h0, 1'b0, "R4 byte");
      run(1'b0, 2'd1, 12'h042, 32'h0, 1'b0, "R4 half");
      run(1'b0, 2'd2, 12'h080, 32'h0, 1'b0, "R4 word");
      run(1'b1, 2'd2, 12'h084, 32'hDEAD_BEEF, 1'b0, "R4 word write");
      run(1'b0, 2'd2, 12'h084, 32'h0, 1'b0, "R4 word readback");
   endtask

   task automatic t_over_read();
      run(1'b0, 2'd2, 12'h008, 32'h0, 1'b0, "R5 word on bytes");
      run(1'b0, 2'd1, 12'h00A, 32'h0, 1'b0, "R5 half on bytes");
      run(1'b0, 2'd2, 12'h044, 32'h0, 1'b0, "R5 word on halves");
      run(1'b0, 2'd1, 12'h1F6, 32'h0, 1'b0, "R5 upper byte group");
   endtask

   task automatic t_over_write();
      run(1'b1, 2'd2, 12'h00C, 32'h1122_3344, 1'b0, "R6 word to bytes");
      run(1'b0, 2'd0, 12'h00C, 32'h0, 1'b0, "R6 byte 0");
      run(1'b0, 2'd0, 12'h00F, 32'h0, 1'b0, "R6 byte 3");
      run(1'b1, 2'd2, 12'h048, 32'hCAFE_F00D, 1'b0, "R6 word to halves");
      run(1'b0, 2'd1, 12'h04A, 32'h0, 1'b0, "R6 low half");
   endtask

   task automatic t_under_read();
      run(1'b0, 2'd0, 12'h043, 32'h0, 1'b0, "R7 odd byte of half");
      run(1'b0, 2'd0, 12'h081, 32'h0, 1'b0, "R7 byte of word");
      run(1'b0, 2'd1, 12'h082, 32'h0, 1'b0, "R7 low half of word");
   endtask

   task automatic t_under_write();
      run(1'b1, 2'd0, 12'h045, 32'h0000_0077, 1'b0, "R8 byte into half");
      run(1'b0, 2'd1, 12'h044, 32'h0, 1'b0, "R8 half preserved");
      run(1'b1, 2'd1, 12'h08A, 32'h0000_9ABC, 1'b0, "R8 half into word");
      run(1'b1, 2'd0, 12'h089, 32'h0000_0055, 1'b0, "R8 byte into word");
      run(1'b0, 2'd2, 12'h088, 32'h0, 1'b0, "R8 word preserved");
   endtask

   task automatic t_errors();
      run(1'b0, 2'd2, 12'h200, 32'h0, 1'b0, "R1 window end");
      run(1'b1, 2'd0, 12'h3FF, 32'h0000_0012, 1'b0, "R1 far offset");
      run(1'b0, 2'd1, 12'h041, 32'h0, 1'b0, "R2 odd half");
      run(1'b0, 2'd2, 12'h082, 32'h0, 1'b0, "R2 unaligned word");
      run(1'b0, 2'd3, 12'h080, 32'h0, 1'b0, "R2 size code 3");
      run(1'b1, 2'd2, 12'h0C0, 32'h1234_5678, 1'b0, "R3 hole block");
      run(1'b0, 2'd0, 12'h101, 32'h0, 1'b0, "R3 upper hole");
   endtask

   task automatic t_busy();
      run(1'b0, 2'd2, 12'h010, 32'h0, 1'b1, "R9 held request");
      run(1'b0, 2'd0, 12'h010, 32'h0, 1'b0, "R9 byte untouched");
   endtask

   task automatic t_image();
      bit same;
      same = 1'b1;
      for (int i = 0; i < 512; i++) if (tmem[i] != rmem[i]) same = 1'b0;
      chk(same, "R8 target image", {31'h0, same}, 32'h1);
   endtask

   initial begin
      for (int i = 0; i < 512; i++) begin
         tmem[i] = 8'(i * 7 + 3);
         rmem[i] = 8'(i * 7 + 3);
      end
      repeat (3) @(negedge clk);
      t_reset();
      t_matched();
      t_over_read();
      t_over_write();
      t_under_read();
      t_under_write();
      t_errors();
      t_busy();
      t_image();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h1, 32'h0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule